// File: doc/BRIEF.md
# System Reset Sequencing Controller

This block merges the chip's reset sources into a single core reset and a separate debug-port reset. It takes three sources. The first is a power-on indication, active high. The second is an external reset pin, active low. The third is the output of a brown-out detector. Software can also request a reset. Both asynchronous reset inputs put the core into reset at once, without waiting for a clock. Their release passes through a two-stage synchronizer. After that, a hold counter must run out before the core reset drops. The core reset therefore follows whichever source lets go last. One clock after release, a single-cycle boot strobe tells the core to fetch its initial stack pointer and program counter.

Only the power-on indication resets the debug port. The pin and the software request leave it running. The brown-out path starts disabled after every core reset. Software arms it with a configuration write, which also selects whether an event raises a held interrupt or a full core reset. The detector output is synchronized and must stay high over two consecutive samples before it counts as an event. A sticky cause register records which sources have reset the core. Software clears its bits by writing ones.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_i` is high, `core_rst_o` and `dbg_rst_o` are high. After `por_i` falls (pin inactive), `dbg_rst_o` falls on the 2nd rising edge and `core_rst_o` falls on the 6th rising edge (2 synchronizer edges plus a hold of 4).
- R2: `core_rst_o` goes high with no clock edge needed whenever `por_i` is high or `pin_rst_n_i` is low.
- R3: When the power-on and pin sources overlap, `core_rst_o` stays high until both are inactive, then falls on the 6th rising edge after the later one deasserts.
- R4: A pin reset of any length is released on the 6th rising edge after `pin_rst_n_i` returns high, and it never raises `dbg_rst_o`.
- R5: `sw_rst_i` high at a rising edge raises `core_rst_o` after that edge and releases it 4 edges later. `dbg_rst_o` stays low.
- R6: `boot_start_o` is high for exactly one cycle, the cycle right after `core_rst_o` falls, and at no other time.
- R7: The brown-out enable is cleared while `core_rst_o` is high. A configuration write (`cfg_wr_i`) made while the core is out of reset loads the enable from `cfg_bod_en_i`. While the enable is clear, brown-out input changes neither `bod_irq_o` nor `core_rst_o`.
- R8: A brown-out event needs `bod_i` high at two consecutive rising edges. A one-cycle pulse is ignored. A level held high produces one event only. The event is seen on the 4th rising edge after `bod_i` rises.
- R9: With the enable set and `cfg_bod_rst_i`=0 at the write, an event sets `bod_irq_o`. It stays set until a cycle with `bod_irq_clr_i` high, and it does not reset the core.
- R10: With the enable set and `cfg_bod_rst_i`=1, an event raises `core_rst_o` and releases it 4 edges later, leaving `dbg_rst_o` low.
- R11: `cause_o` has bit 0 for power-on, bit 1 for pin, bit 2 for brown-out and bit 3 for software. A power-on reset leaves exactly 4'b0001. Other sources OR in their bit. A one in `cause_clr_i` clears that bit and leaves the others alone. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| bod_i | input | 1 | Brown-out detector output, active high, asynchronous |
| sw_rst_i | input | 1 | Software reset request, sampled each edge |
| cfg_wr_i | input | 1 | Write strobe for the brown-out configuration |
| cfg_bod_en_i | input | 1 | Brown-out enable value to write |
| cfg_bod_rst_i | input | 1 | Brown-out action to write: 1 reset, 0 interrupt |
| bod_irq_clr_i | input | 1 | Clears the brown-out interrupt |
| cause_clr_i | input | 4 | Write-one-to-clear mask for the cause bits |
| core_rst_o | output | 1 | Core reset, active high |
| dbg_rst_o | output | 1 | Debug-port reset, active high |
| boot_start_o | output | 1 | One-cycle strobe after core reset release |
| bod_irq_o | output | 1 | Brown-out interrupt, level held |
| cause_o | output | 4 | Sticky reset cause bits |

## Verification
The release count is swept over pin reset lengths of one to five cycles. A fixed edge count after every length shows that the hold runs from the deassertion and not from the assertion. The power-on and pin sources are overlapped in both orders, which separates "later of the two" from "first to clear". Software and brown-out reset requests show the four-edge path that bypasses the synchronizer. They also show that only power-on touches the debug reset. Brown-out pulses of one to four cycles, plus a long held level, separate the stability filter from the rising-edge event detection, and the interrupt and reset actions are each tried with the enable set and clear.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_BOD = 2;
  localparam int CAUSE_SW  = 3;
endpackage

// File: rtl/rst_async_sync.sv
// Asserts at once on the asynchronous input, releases after STAGES edges.
module rst_async_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_i,
  output logic srst_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst_i) begin
    if (arst_i) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign srst_o = chain_q[STAGES-1];
endmodule

// File: rtl/bod_filter.sv
// Synchronizes the detector output and flags one event per stable high level.
module bod_filter #(
  parameter int SYNC   = 2,
  parameter int STABLE = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic bod_i,
  output logic evt_o
);
  localparam int LEN = SYNC + STABLE - 1;

  logic [LEN-1:0] hist_q;
  logic           lvl_q;
  logic           lvl;

  assign lvl   = &hist_q[LEN-1:SYNC-1];
  assign evt_o = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= {hist_q[LEN-2:0], bod_i};
      lvl_q  <= lvl;
    end
  end
endmodule

// File: rtl/rst_hold_ctrl.sv
// Holds reset for HOLD cycles after the last request, then strobes boot.
module rst_hold_ctrl #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic req_i,
  output logic rst_o,
  output logic boot_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] cnt_q;
  logic          rst_q;
  logic          boot_q;

  always_ff @(posedge clk) begin
    if (req_i) begin
      rst_q  <= 1'b1;
      cnt_q  <= '0;
      boot_q <= 1'b0;
    end else if (rst_q) begin
      if (cnt_q == CW'(HOLD - 1)) begin
        rst_q  <= 1'b0;
        boot_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
        boot_q <= 1'b0;
      end
    end else begin
      boot_q <= 1'b0;
    end
  end

  assign rst_o  = rst_q;
  assign boot_o = boot_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int BOD_STABLE  = 2
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               pin_rst_n_i,
  input  logic               bod_i,
  input  logic               sw_rst_i,
  input  logic               cfg_wr_i,
  input  logic               cfg_bod_en_i,
  input  logic               cfg_bod_rst_i,
  input  logic               bod_irq_clr_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  output logic               core_rst_o,
  output logic               dbg_rst_o,
  output logic               boot_start_o,
  output logic               bod_irq_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic pin_arst;
  logic por_s, pin_s;
  logic bod_evt, bor_evt, bod_int_evt;
  logic hold_rst, req_any;
  logic bod_en_q, bod_mode_q, irq_q;
  logic [CAUSE_W-1:0] cause_q, cause_set;

  assign pin_arst = ~pin_rst_n_i;

  rst_async_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_i(por_i), .srst_o(por_s));

  rst_async_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .arst_i(pin_arst), .srst_o(pin_s));

  bod_filter #(.SYNC(SYNC_STAGES), .STABLE(BOD_STABLE)) u_bod_filt (
    .clk(clk), .rst_i(por_s), .bod_i(bod_i), .evt_o(bod_evt));

  assign bor_evt     = bod_evt & bod_en_q &  bod_mode_q;
  assign bod_int_evt = bod_evt & bod_en_q & ~bod_mode_q;
  assign req_any     = por_s | pin_s | sw_rst_i | bor_evt;

  rst_hold_ctrl #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .req_i(req_any), .rst_o(hold_rst), .boot_o(boot_start_o));

  // Asynchronous sources reach the core reset without waiting for the hold.
  assign core_rst_o = hold_rst | por_s | pin_s;
  assign dbg_rst_o  = por_s;

  always_ff @(posedge clk) begin
    if (core_rst_o) begin
      bod_en_q   <= 1'b0;
      bod_mode_q <= 1'b0;
    end else if (cfg_wr_i) begin
      bod_en_q   <= cfg_bod_en_i;
      bod_mode_q <= cfg_bod_rst_i;
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst_o)         irq_q <= 1'b0;
    else if (bod_int_evt)   irq_q <= 1'b1;
    else if (bod_irq_clr_i) irq_q <= 1'b0;
  end
  assign bod_irq_o = irq_q;

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_PIN] = pin_s;
    cause_set[CAUSE_BOD] = bor_evt;
    cause_set[CAUSE_SW]  = sw_rst_i;
  end

  always_ff @(posedge clk) begin
    if (por_s) begin
      cause_q            <= '0;
      cause_q[CAUSE_POR] <= 1'b1;
    end else begin
      cause_q <= (cause_q & ~cause_clr_i) | cause_set;
    end
  end
  assign cause_o = cause_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por_i,
  input logic       pin_rst_n_i,
  input logic       bod_i,
  input logic       bod_irq_clr_i,
  input logic       core_rst_o,
  input logic       dbg_rst_o,
  input logic       boot_start_o,
  input logic       bod_irq_o,
  input logic [3:0] cause_o
);
  assert_pin_holds_core_R2: assert property (@(posedge clk) disable iff (por_i)
    !pin_rst_n_i |-> core_rst_o);

  assert_release_strobes_boot_R6: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> boot_start_o);

  assert_boot_follows_reset_R6: assert property (@(posedge clk) disable iff (por_i)
    boot_start_o |-> $past(core_rst_o));

  assert_irq_needs_stable_bod_R8: assert property (@(posedge clk) disable iff (por_i)
    $rose(bod_irq_o) |-> ($past(bod_i, 3) && $past(bod_i, 4)));

  assert_irq_held_R9: assert property (@(posedge clk) disable iff (por_i)
    (bod_irq_o && !bod_irq_clr_i && !core_rst_o) |=> bod_irq_o);

  assert_dbg_release_logs_por_R1: assert property (@(posedge clk) disable iff (por_i)
    $fell(dbg_rst_o) |-> cause_o[0]);
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk(clk), .por_i(por_i), .pin_rst_n_i(pin_rst_n_i), .bod_i(bod_i),
  .bod_irq_clr_i(bod_irq_clr_i), .core_rst_o(core_rst_o), .dbg_rst_o(dbg_rst_o),
  .boot_start_o(boot_start_o), .bod_irq_o(bod_irq_o), .cause_o(cause_o));

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  localparam int SYNC = 2;
  localparam int HOLD = 4;
  localparam int REL  = SYNC + HOLD;
  localparam int BODLAT = 4;

  logic clk = 1'b0;
  logic por = 1'b0, pin_n = 1'b1, bod = 1'b0, sw = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_rst = 1'b0, irq_clr = 1'b0;
  logic [3:0] cclr = 4'h0;
  logic core_rst, dbg_rst, boot, irq;
  logic [3:0] cause;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .BOD_STABLE(2)) dut (
    .clk(clk), .por_i(por), .pin_rst_n_i(pin_n), .bod_i(bod), .sw_rst_i(sw),
    .cfg_wr_i(cfg_wr), .cfg_bod_en_i(cfg_en), .cfg_bod_rst_i(cfg_rst),
    .bod_irq_clr_i(irq_clr), .cause_clr_i(cclr), .core_rst_o(core_rst),
    .dbg_rst_o(dbg_rst), .boot_start_o(boot), .bod_irq_o(irq), .cause_o(cause));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Counts edges after an asynchronous source is released at a negedge.
  task automatic check_release(input string tag, input int dbg_edges);
    for (int k = 1; k <= REL + 1; k++) begin
      tick();
      chk({tag, " core"}, core_rst, (k < REL) ? 1 : 0);
      chk({tag, " boot R6"}, boot, (k == REL) ? 1 : 0);
      chk({tag, " dbg"}, dbg_rst, (k < dbg_edges) ? 1 : 0);
    end
  endtask

  task automatic write_cfg(input logic en, input logic mode);
    cfg_wr = 1'b1; cfg_en = en; cfg_rst = mode;
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1 por = 1'b1;
    #1;
    chk("R2 core before any edge", core_rst, 1);
    chk("R1 dbg during power-on", dbg_rst, 1);
    @(negedge clk);
    repeat (3) tick();
    por = 1'b0;
    check_release("R1 power-on release", SYNC);
    chk("R11 cause after power-on", cause, 4'b0001);

    // R4: pin reset lengths 1..5
    for (int w = 1; w <= 5; w++) begin
      pin_n = 1'b0;
      #1;
      chk("R2 pin asserts at once", core_rst, 1);
      chk("R4 pin leaves dbg", dbg_rst, 0);
      repeat (w) tick();
      pin_n = 1'b1;
      check_release("R4 pin release", 0);
    end
    chk("R11 cause after pin", cause, 4'b0011);

    cclr = 4'b0001;
    tick();
    cclr = 4'b0000;
    chk("R11 clear power-on bit only", cause, 4'b0010);

    // R5 software reset, with R11 set-wins-over-clear
    sw = 1'b1; cclr = 4'b1010;
    tick();
    sw = 1'b0; cclr = 4'b0000;
    chk("R5 sw asserts core", core_rst, 1);
    chk("R11 set beats clear", cause, 4'b1000);
    for (int k = 2; k <= HOLD + 2; k++) begin
      tick();
      chk("R5 sw hold", core_rst, (k <= HOLD) ? 1 : 0);
      chk("R6 sw boot", boot, (k == HOLD + 1) ? 1 : 0);
      chk("R5 sw leaves dbg", dbg_rst, 0);
    end

    // R3: power-on released first, pin later
    por = 1'b1; pin_n = 1'b0;
    repeat (2) tick();
    por = 1'b0;
    repeat (10) tick();
    chk("R3 pin still holds core", core_rst, 1);
    chk("R3 dbg released", dbg_rst, 0);
    pin_n = 1'b1;
    check_release("R3 later pin", 0);

    // R3: pin released first, power-on later
    por = 1'b1; pin_n = 1'b0;
    repeat (2) tick();
    pin_n = 1'b1;
    repeat (10) tick();
    chk("R3 power-on still holds core", core_rst, 1);
    por = 1'b0;
    check_release("R3 later power-on", SYNC);
    chk("R11 power-on leaves only bit0", cause, 4'b0001);

    // R7: disabled after reset
    bod = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R7 disabled irq", irq, 0);
      chk("R7 disabled core", core_rst, 0);
    end
    bod = 1'b0;
    repeat (4) tick();

    // R8/R9: pulse widths in interrupt mode
    write_cfg(1'b1, 1'b0);
    for (int w = 1; w <= 4; w++) begin
      bod = 1'b1;
      for (int k = 1; k <= 8; k++) begin
        tick();
        if (k == w) bod = 1'b0;
        chk("R8 irq after filter", irq, (w >= 2 && k >= BODLAT) ? 1 : 0);
        chk("R9 irq keeps core", core_rst, 0);
      end
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R9 irq cleared", irq, 0);
      repeat (2) tick();
    end

    // R8: held level gives a single event
    bod = 1'b1;
    repeat (6) tick();
    chk("R8 held level irq", irq, 1);
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    repeat (5) tick();
    chk("R8 no second event", irq, 0);
    bod = 1'b0;
    repeat (4) tick();

    // R10: reset mode
    write_cfg(1'b1, 1'b1);
    bod = 1'b1;
    for (int k = 1; k <= BODLAT + HOLD + 1; k++) begin
      tick();
      if (k == 3) bod = 1'b0;
      chk("R10 bod core", core_rst, (k >= BODLAT && k < BODLAT + HOLD) ? 1 : 0);
      chk("R10 bod dbg", dbg_rst, 0);
      chk("R10 bod no irq", irq, 0);
      chk("R6 bod boot", boot, (k == BODLAT + HOLD) ? 1 : 0);
    end
    chk("R11 bod cause", cause, 4'b0101);

    // R7: enable cleared by that reset
    bod = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R7 enable cleared core", core_rst, 0);
      chk("R7 enable cleared irq", irq, 0);
    end
    bod = 1'b0;
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule